// File: doc/BRIEF.md
# Process-Tagged Write-Back Data Cache

A direct-mapped data cache placed between a 32-bit processor load/store port and a memory port that moves one 32-bit word per handshake. Lines are tagged with the untranslated (virtual) address bits above the cache span and with the identifier of the process that filled them. Each line also carries a modified flag. With the defaults the cache holds 256 lines of 8 words (8 KB). A miss on a modified line first copies the old line back to memory and then reloads the line one word at a time.

The processor port is a request/ready pair. The request and its operands must stay stable until `cpu_ready` is seen high. Byte, halfword and word accesses are supported, with a pin that selects big-endian byte lanes. Addresses in the peripheral segment skip the cache and go to the memory port as a single transfer. A fault input on the memory side can cut a refill short. The access then ends with a fault flag, and the line is left empty.

Top module: `vtag_wb_cache`

## Requirements
- R1: After reset no line is valid for any address outside 0xFFFF0000..0xFFFF1FFF. The first cacheable access to each line therefore reads a full line of words from memory.
- R2: A cacheable hit raises `cpu_ready` in the same cycle the request is presented and causes no memory-port traffic.
- R3: On a miss whose victim line is clean, the block reads the words of the line at the requested line's base address, in ascending order. `cpu_ready` stays low until the access has completed from the refilled line.
- R4: On a miss whose victim line is modified, all words of the victim are first written to memory at the address formed from the old tag and the same index. The refill starts only after that.
- R5: Every completed cacheable write marks its line modified. A line that has only been refilled and read is clean, so its eviction writes nothing back.
- R6: When the address tag matches but the stored process identifier differs from `cpu_pid`, the access is a miss if it is a write or if address bits [31:28] are not 0x1. A read in the 0x1 segment still hits.
- R7: An access with address bits [31:28] equal to 0x2 goes straight to the memory port with the processor's address, size and data. It completes on `mem_ack` and leaves the cache contents untouched.
- R8: `cpu_size` encodes 0 as byte, 1 as halfword and 2 as word. The byte lane is the low two address bits XOR 3 when `big_endian` is 1, or taken as is when it is 0. A byte read returns bits [8*lane+7:8*lane], zero-extended. A halfword read returns bits [16*lane[1]+15:16*lane[1]], zero-extended.
- R9: A byte or halfword write copies the data across all lanes and changes only the selected lane(s) of the stored word.
- R10: `mem_abort` during a refill ends the access in that cycle with `cpu_ready` and `cpu_fault` both high. The line is left invalid, so a retry refetches it and returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, low-aligned for sub-word |
| cpu_pid | input | PID_W | Current process identifier |
| big_endian | input | 1 | Selects big-endian byte lanes |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_fault | output | 1 | Completing access was aborted |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_size | output | 2 | Transfer size, same encoding as cpu_size |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Transfer accepted this cycle |
| mem_abort | input | 1 | Memory fault, aborts a refill |

## Verification
The bench builds the cache with 4 lines of 2 words and a 2-bit process identifier, so the whole cache spans 32 bytes. At that size every byte offset, size and endianness of every line can be read back after a full fill. Addresses 32 bytes apart collide at the same index, which makes write-back counts, clean evictions, identifier mismatches and an aborted refill each reachable in a few accesses. Memory traffic is counted at the port and compared with counts worked out from the line size.

// File: rtl/vtag_wb_cache.sv
module vtag_wb_cache #(
  parameter int IDX_W = 8,
  parameter int OFF_W = 3,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [1:0]       cpu_size,
  input  logic [31:0]      cpu_addr,
  input  logic [31:0]      cpu_wdata,
  input  logic [PID_W-1:0] cpu_pid,
  input  logic             big_endian,
  output logic             cpu_ready,
  output logic             cpu_fault,
  output logic [31:0]      cpu_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_abort
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int CSZ   = IDX_W + OFF_W + 2;
  localparam int TAG_W = 32 - CSZ;
  localparam logic [31:0]      INIT_TAG = 32'hFFFF_0000;
  localparam logic [TAG_W-1:0] INIT_HI  = INIT_TAG[31:CSZ];
  localparam logic [OFF_W-1:0] LAST     = '1;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} state_t;
  state_t state;

  logic [TAG_W-1:0] tag_hi  [LINES];
  logic [PID_W-1:0] tag_pid [LINES];
  logic [LINES-1:0] tag_dirty;
  logic [31:0]      data    [LINES*WORDS];
  logic [OFF_W-1:0] cnt;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] woff;
  logic [TAG_W-1:0] a_hi;
  logic bypass, shared, tag_match, pid_ok, hit;
  logic [1:0]  lane;
  logic [31:0] line_word, rd_cache, wrep, wmask;

  assign idx    = cpu_addr[CSZ-1:OFF_W+2];
  assign woff   = cpu_addr[OFF_W+1:2];
  assign a_hi   = cpu_addr[31:CSZ];
  assign bypass = cpu_addr[31:28] == 4'h2;
  assign shared = cpu_addr[31:28] == 4'h1;

  assign tag_match = tag_hi[idx] == a_hi;
  assign pid_ok    = tag_pid[idx] == cpu_pid;
  assign hit       = tag_match && (pid_ok || (!cpu_we && shared));

  assign line_word = data[{idx, woff}];
  assign lane      = cpu_addr[1:0] ^ {2{big_endian}};

  always_comb begin
    case (cpu_size)
      2'd0: begin
        rd_cache = (line_word >> {lane, 3'b000}) & 32'h0000_00FF;
        wrep     = {4{cpu_wdata[7:0]}};
        wmask    = 32'h0000_00FF << {lane, 3'b000};
      end
      2'd1: begin
        rd_cache = (line_word >> {lane[1], 4'b0000}) & 32'h0000_FFFF;
        wrep     = {2{cpu_wdata[15:0]}};
        wmask    = 32'h0000_FFFF << {lane[1], 4'b0000};
      end
      default: begin
        rd_cache = line_word;
        wrep     = cpu_wdata;
        wmask    = 32'hFFFF_FFFF;
      end
    endcase
  end

  logic idle_req, wr_hit, miss, wb_done, fill_step, fill_done, aborted;
  assign idle_req  = state == S_IDLE && cpu_req;
  assign wr_hit    = idle_req && !bypass && hit && cpu_we;
  assign miss      = idle_req && !bypass && !hit;
  assign wb_done   = state == S_WB && mem_ack && cnt == LAST;
  assign aborted   = state == S_FILL && mem_abort;
  assign fill_step = state == S_FILL && mem_ack && !mem_abort;
  assign fill_done = fill_step && cnt == LAST;

  assign cpu_ready = (idle_req && (bypass ? mem_ack : hit)) || aborted;
  assign cpu_fault = aborted;
  assign cpu_rdata = bypass ? mem_rdata : rd_cache;

  assign mem_req  = (idle_req && bypass) || state != S_IDLE;
  assign mem_we   = (state == S_IDLE) ? cpu_we : (state == S_WB);
  assign mem_size = (state == S_IDLE) ? cpu_size : 2'd2;

  always_comb begin
    case (state)
      S_WB:    mem_addr = {tag_hi[idx], idx, cnt, 2'b00};
      S_FILL:  mem_addr = {a_hi, idx, cnt, 2'b00};
      default: mem_addr = cpu_addr;
    endcase
  end
  assign mem_wdata = (state == S_WB) ? data[{idx, cnt}] : cpu_wdata;

  always_ff @(posedge clk) begin
    if (wr_hit)
      data[{idx, woff}] <= (line_word & ~wmask) | (wrep & wmask);
    else if (fill_step)
      data[{idx, cnt}] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      tag_dirty <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_hi[i]  <= INIT_HI;
        tag_pid[i] <= INIT_TAG[PID_W:1];
      end
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (wr_hit) tag_dirty[idx] <= 1'b1;
          if (miss) begin
            if (tag_dirty[idx]) state <= S_WB;
            else begin
              state          <= S_FILL;
              tag_hi[idx]    <= INIT_HI;
              tag_pid[idx]   <= '0;
            end
          end
        end
        S_WB: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (wb_done) begin
            state          <= S_FILL;
            tag_hi[idx]    <= INIT_HI;
            tag_pid[idx]   <= '0;
            tag_dirty[idx] <= 1'b0;
          end
        end
        S_FILL: begin
          if (aborted) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else if (mem_ack) begin
            cnt <= cnt + 1'b1;
            if (fill_done) begin
              state          <= S_IDLE;
              tag_hi[idx]    <= a_hi;
              tag_pid[idx]   <= cpu_pid;
              tag_dirty[idx] <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_busy_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !mem_abort) |-> !cpu_ready);

  assert_wb_then_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && mem_ack && cnt == LAST) |=> (state == S_FILL && cnt == '0));

  assert_write_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_req && cpu_we && !bypass && cpu_ready) |=> tag_dirty[$past(idx)]);

  assert_fill_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ack && !mem_abort && cnt == LAST) |=>
      (tag_pid[$past(idx)] == $past(cpu_pid) && tag_hi[$past(idx)] == $past(a_hi)
       && !tag_dirty[$past(idx)]));

  assert_bypass_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_req && bypass) |=> state == S_IDLE);

  assert_abort_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_abort) |=> (state == S_IDLE && tag_hi[$past(idx)] == INIT_HI));
endmodule

// File: tb/vtag_wb_cache_bench.sv
module vtag_wb_cache_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  always #(CLK_P/2) clk = ~clk;

  logic        req = 0, we = 0, be = 1;
  logic [1:0]  size = 2, pid = 1;
  logic [31:0] addr = 0, wdata = 0;
  logic        cpu_ready, cpu_fault;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        mem_ack = 0, mem_abort = 0;

  vtag_wb_cache #(.IDX_W(2), .OFF_W(1), .PID_W(2)) u_vtag_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_size(size),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_pid(pid), .big_endian(be),
    .cpu_ready(cpu_ready), .cpu_fault(cpu_fault), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_abort(mem_abort));

  logic [31:0] mem [128];
  logic [31:0] ref_m [128];
  logic [31:0] periph [4];
  int cnt_rd = 0, cnt_wr = 0, fill_seen = 0, abort_at = -1;
  int errors = 0, checks = 0;
  logic done = 0;

  function automatic int widx(input logic [31:0] a);
    return {a[28], a[7:2]};
  endfunction

  function automatic logic [31:0] rd_ext(input logic [31:0] w, input logic [1:0] a,
                                         input logic [1:0] sz, input logic e);
    logic [1:0] ln = a ^ {e, e};
    case (sz)
      2'd0: return (w >> (8 * ln)) & 32'hFF;
      2'd1: return (w >> (16 * ln[1])) & 32'hFFFF;
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [1:0] a, input logic [1:0] sz, input logic e);
    logic [1:0] ln = a ^ {e, e};
    logic [31:0] m, v;
    case (sz)
      2'd0: begin m = 32'hFF << (8 * ln); v = {4{d[7:0]}}; end
      2'd1: begin m = 32'hFFFF << (16 * ln[1]); v = {2{d[15:0]}}; end
      default: begin m = '1; v = d; end
    endcase
    return (old & ~m) | (v & m);
  endfunction

  // memory responder: acts on the falling edge, one ack every other cycle
  always @(negedge clk) begin
    if (mem_ack || mem_abort) begin
      mem_ack <= 0; mem_abort <= 0;
    end else if (mem_req) begin
      if (!mem_we && mem_addr[31:28] != 4'h2 && abort_at >= 0 && fill_seen == abort_at) begin
        mem_abort <= 1; abort_at = -1;
      end else begin
        mem_ack <= 1;
        if (mem_addr[31:28] == 4'h2) mem_rdata <= periph[mem_addr[3:2]];
        else begin
          mem_rdata <= mem[widx(mem_addr)];
          if (!mem_we) fill_seen++;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_addr[31:28] == 4'h2) begin
        if (mem_we) periph[mem_addr[3:2]] <= mem_wdata;
      end else if (mem_we) begin
        mem[widx(mem_addr)] <= mem_wdata;
        cnt_wr++;
      end else cnt_rd++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic flt,
                     output int lat);
    @(posedge clk); #1;
    req = 1; we = w; size = sz; addr = a; wdata = d; lat = 0;
    forever begin
      @(negedge clk); #1;
      if (cpu_ready) break;
      lat++;
    end
    rd = cpu_rdata; flt = cpu_fault;
    @(posedge clk); #1;
    req = 0;
    if (w && !flt && a[31:28] != 4'h2) begin
      ref_m[widx(a)] = merge(ref_m[widx(a)], d, a[1:0], sz, be);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic flt;
    int lat, r0, w0;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 32'h9E37_79B9 * (i + 1);
      ref_m[i] = mem[i];
    end
    for (int i = 0; i < 4; i++) periph[i] = 32'h5A00_0000 + i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", {31'b0, cpu_ready}, 0);
    chk("R1 reset mem_req", {31'b0, mem_req}, 0);

    // fill the whole cache with word writes, process 1
    pid = 1; be = 1;
    for (int a = 0; a < 32; a += 4) begin
      acc(1, 2, a, 32'hA0B1_C2D3 ^ (a * 32'h0101_0101), rd, flt, lat);
      if (a % 8 == 4) chk("R2 write hit latency", lat, 0);
    end
    chk("R1 cold misses read full lines", cnt_rd, 8);
    chk("R5 no write-back yet", cnt_wr, 0);

    // every offset, size and endianness read back from the full cache
    r0 = cnt_rd;
    for (int e = 0; e < 2; e++) begin
      be = e[0];
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 32; a += (1 << sz)) begin
          acc(0, sz[1:0], a, 0, rd, flt, lat);
          chk("R8 lane read", rd, rd_ext(ref_m[widx(a)], a[1:0], sz[1:0], e[0]));
          if (a == 0) chk("R2 read hit latency", lat, 0);
        end
    end
    chk("R2 hits read no memory", cnt_rd, r0);

    // conflicting lines evict modified victims
    be = 1; r0 = cnt_rd; w0 = cnt_wr;
    for (int a = 32; a < 64; a += 8) begin
      acc(0, 2, a, 0, rd, flt, lat);
      chk("R3 miss refill data", rd, ref_m[widx(a)]);
    end
    chk("R4 write-back count", cnt_wr - w0, 8);
    chk("R3 refill count", cnt_rd - r0, 8);
    for (int a = 0; a < 32; a += 4) chk("R4 written back content", mem[widx(a)], ref_m[widx(a)]);
    // clean lines evict without write-back
    w0 = cnt_wr;
    acc(0, 2, 32'h0000_0080, 0, rd, flt, lat);
    chk("R5 clean eviction", cnt_wr - w0, 0);
    chk("R3 clean miss data", rd, ref_m[widx(32'h80)]);

    // sub-word writes in both byte orders
    for (int e = 0; e < 2; e++) begin
      be = e[0];
      for (int sz = 0; sz < 2; sz++)
        for (int o = 0; o < 4; o += (1 << sz)) begin
          acc(1, sz[1:0], 32'h40 + o, 32'h1234_5600 + (e * 16 + sz * 4 + o), rd, flt, lat);
          acc(0, 2, 32'h40, 0, rd, flt, lat);
          chk("R9 merged word", rd, ref_m[widx(32'h40)]);
        end
    end

    // process identifier handling
    be = 1; pid = 1;
    acc(1, 2, 32'h1000_0000, 32'hCAFE_0001, rd, flt, lat);
    r0 = cnt_rd; pid = 2;
    acc(0, 2, 32'h1000_0000, 0, rd, flt, lat);
    chk("R6 shared read other pid hits", lat, 0);
    chk("R6 shared read data", rd, 32'hCAFE_0001);
    chk("R6 shared read no traffic", cnt_rd - r0, 0);
    w0 = cnt_wr;
    acc(1, 2, 32'h1000_0004, 32'hCAFE_0002, rd, flt, lat);
    chk("R6 shared write other pid misses", cnt_rd - r0, 2);
    chk("R6 dirty victim written", cnt_wr - w0, 2);
    chk("R6 victim content", mem[widx(32'h1000_0000)], 32'hCAFE_0001);
    pid = 1;
    acc(0, 2, 32'h28, 0, rd, flt, lat);
    chk("R6 same pid private hit", lat, 0);
    r0 = cnt_rd; pid = 2;
    acc(0, 2, 32'h28, 0, rd, flt, lat);
    chk("R6 private read other pid misses", cnt_rd - r0, 2);
    chk("R6 private reread data", rd, ref_m[widx(32'h28)]);

    // peripheral bypass
    r0 = cnt_rd; w0 = cnt_wr;
    acc(1, 2, 32'h2000_0008, 32'hFEED_BEEF, rd, flt, lat);
    chk("R7 bypass write reaches port", periph[2], 32'hFEED_BEEF);
    acc(0, 2, 32'h2000_0008, 0, rd, flt, lat);
    chk("R7 bypass read", rd, 32'hFEED_BEEF);
    chk("R7 no cacheable reads", cnt_rd - r0, 0);
    chk("R7 no cacheable writes", cnt_wr - w0, 0);
    acc(0, 2, 32'h28, 0, rd, flt, lat);
    chk("R7 cache line kept", lat, 0);

    // aborted refill
    pid = 2; be = 1;
    fill_seen = 0; abort_at = 1;
    w0 = cnt_wr; r0 = cnt_rd;
    acc(0, 2, 32'h0000_00A0, 0, rd, flt, lat);
    chk("R10 fault flagged", {31'b0, flt}, 1);
    chk("R10 partial refill", cnt_rd - r0, 1);
    chk("R10 victim written first", cnt_wr - w0, 2);
    r0 = cnt_rd;
    acc(0, 2, 32'h0000_00A0, 0, rd, flt, lat);
    chk("R10 retry no fault", {31'b0, flt}, 0);
    chk("R10 retry refetch", cnt_rd - r0, 2);
    chk("R10 retry data", rd, ref_m[widx(32'hA0)]);

    done = 1;
    summary();
    $finish;
  end
endmodule